// File: doc/BRIEF.md
# Instrument Status Reporting Unit

This block keeps the status and event registers of a bus-attached instrument. Single-cycle event pulses from the instrument core latch into an 8-bit event register. An enable mask folds that register into one event-summary bit of the status byte. The status byte also carries a message-available bit that follows an external queue-not-empty flag, and five instrument-specific summary bits taken straight from input pins. A second enable mask reduces the status byte to a master summary. A rising edge of the master summary sets a request latch, and the latch drives the service-request output.

Software uses a small host port. It presents a 3-bit operation code for one cycle. Read data is combinational in that cycle, and any side effect (a clear or a mask write) takes place at the closing clock edge. Two of the operations return the status byte. The status query puts the live master summary in bit 6 and leaves all state alone. The serial poll puts the request latch in bit 6 and clears that latch.

Top module: `stat_report_unit`

## Requirements
- R1: Event register bit map: 0 operation complete, 1 request control, 2 query error, 3 device error, 4 execution error, 5 command error, 6 user request, 7 power on. A 1 on `evtPulse[i]` at a clock edge sets bit i. The bit stays set after the pulse ends, until it is read.
- R2: Operation code 1 returns the event register and clears it at the same edge. A pulse that arrives in that cycle is set after the clear.
- R3: Code 3 writes `hostWrData` to the event enable mask and code 2 reads that mask back. Code 5 writes the service enable mask and code 4 reads it back. No other code changes either mask. The event register and the status byte have no write path.
- R4: Status byte bit 5 is 1 exactly when some event register bit and its event enable mask bit are both 1.
- R5: Status byte bit 4 equals `queueNotEmpty`.
- R6: Status byte bits 0 to 3 equal `userSum[3:0]`, and bit 7 equals `userSum[4]`.
- R7: The master summary is the OR of (status byte AND service enable mask), with bit 6 left out. Code 6 (status query) returns the status byte with the master summary in bit 6 and changes no state.
- R8: The request latch sets on the cycle after the master summary rises from 0 to 1. `srqOut` equals the latch, and the latch stays set until a serial poll clears it.
- R9: Code 7 (serial poll) returns the status byte with the request latch in bit 6 and clears the latch. If the master summary rises in that same cycle, the latch stays set.
- R10: After reset the event register, both masks and `srqOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostOp | input | 3 | Host operation code; 0 is idle |
| hostWrData | input | 8 | Mask value used by the write codes |
| hostRdData | output | 8 | Combinational read data for the current code |
| evtPulse | input | 8 | Event pulses, one per event register bit |
| queueNotEmpty | input | 1 | Output queue holds data |
| userSum | input | 5 | Instrument-specific summaries for status bits 0-3 and 7 |
| srqOut | output | 1 | Service request, equal to the request latch |

## Verification
The bench builds the block with its default 8-bit byte, which makes the whole mask space small enough to sweep. It tries every one of the 256 event enable masks against several latched event patterns, and every one of the 256 service enable masks against a busy and an idle status byte. It also walks all 64 combinations of the queue flag and the summary pins. Directed sequences then hit the timing corners: a pulse that coincides with a clear, a summary rise that coincides with a poll, and the two-cycle path from an event pulse through the event summary to `srqOut`.

// File: rtl/stat_report_pkg.sv
package stat_report_pkg;
  localparam int MAV_POS = 4;
  localparam int ESB_POS = 5;
  localparam int MSS_POS = 6;
  localparam int SUM_GAP = 3;

  typedef enum logic [2:0] {
    OP_IDLE       = 3'd0,
    OP_RD_EVT     = 3'd1,
    OP_RD_EVTMASK = 3'd2,
    OP_WR_EVTMASK = 3'd3,
    OP_RD_SRQMASK = 3'd4,
    OP_WR_SRQMASK = 3'd5,
    OP_QUERY      = 3'd6,
    OP_POLL       = 3'd7
  } hostOp_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EVT,
    SEL_EVTMASK,
    SEL_SRQMASK,
    SEL_QUERY,
    SEL_POLL
  } rdSel_e;

  typedef struct packed {
    logic   clrEvt;
    logic   wrEvtMask;
    logic   wrSrqMask;
    logic   clrRqs;
    rdSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/stat_report_ctrl.sv
module stat_report_ctrl
  import stat_report_pkg::*;
(
  input  logic [2:0]  hostOp,
  output ctrlStrobe_t strobe
);
  always_comb begin
    strobe = '{clrEvt: 1'b0, wrEvtMask: 1'b0, wrSrqMask: 1'b0,
               clrRqs: 1'b0, rdSel: SEL_NONE};
    case (hostOp_e'(hostOp))
      OP_RD_EVT:     begin strobe.clrEvt = 1'b1; strobe.rdSel = SEL_EVT; end
      OP_RD_EVTMASK: strobe.rdSel = SEL_EVTMASK;
      OP_WR_EVTMASK: strobe.wrEvtMask = 1'b1;
      OP_RD_SRQMASK: strobe.rdSel = SEL_SRQMASK;
      OP_WR_SRQMASK: strobe.wrSrqMask = 1'b1;
      OP_QUERY:      strobe.rdSel = SEL_QUERY;
      OP_POLL:       begin strobe.clrRqs = 1'b1; strobe.rdSel = SEL_POLL; end
      default:       ;
    endcase
  end
endmodule

// File: rtl/stat_report_dp.sv
module stat_report_dp
  import stat_report_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int USER_W = BYTE_W - SUM_GAP
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [BYTE_W-1:0] evtPulse,
  input  logic              queueNotEmpty,
  input  logic [USER_W-1:0] userSum,
  output logic [BYTE_W-1:0] rdData,
  output logic              srqOut,
  output logic [BYTE_W-1:0] evtReg,
  output logic [BYTE_W-1:0] evtMask,
  output logic [BYTE_W-1:0] srqMask,
  output logic              mss
);
  logic [BYTE_W-1:0] evtNext;
  logic [BYTE_W-1:0] stbBase;
  logic [BYTE_W-1:0] stbQuery;
  logic [BYTE_W-1:0] stbPoll;
  logic              esb;
  logic              mssPrev;
  logic              rqsLatch;
  logic              mssRise;

  // a pulse in the read cycle is ORed in after the clear
  for (genvar i = 0; i < BYTE_W; i++) begin : g_evt
    assign evtNext[i] = (evtReg[i] & ~strobe.clrEvt) | evtPulse[i];
  end

  assign esb = |(evtReg & evtMask);

  // place the summary inputs around the three fixed positions
  for (genvar p = 0; p < BYTE_W; p++) begin : g_stb
    if (p == MAV_POS) begin : g_mav
      assign stbBase[p] = queueNotEmpty;
    end else if (p == ESB_POS) begin : g_esb
      assign stbBase[p] = esb;
    end else if (p == MSS_POS) begin : g_mss
      assign stbBase[p] = 1'b0;
    end else if (p < MAV_POS) begin : g_low
      assign stbBase[p] = userSum[p];
    end else begin : g_high
      assign stbBase[p] = userSum[p-SUM_GAP];
    end
  end

  // bit 6 of stbBase is always 0, so it never feeds the summary
  assign mss     = |(stbBase & srqMask);
  assign mssRise = mss & ~mssPrev;

  always_comb begin
    stbQuery          = stbBase;
    stbQuery[MSS_POS] = mss;
    stbPoll           = stbBase;
    stbPoll[MSS_POS]  = rqsLatch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtReg   <= '0;
      evtMask  <= '0;
      srqMask  <= '0;
      mssPrev  <= 1'b0;
      rqsLatch <= 1'b0;
    end else begin
      evtReg   <= evtNext;
      mssPrev  <= mss;
      rqsLatch <= (rqsLatch & ~strobe.clrRqs) | mssRise;
      if (strobe.wrEvtMask) evtMask <= wrData;
      if (strobe.wrSrqMask) srqMask <= wrData;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_EVT:     rdData = evtReg;
      SEL_EVTMASK: rdData = evtMask;
      SEL_SRQMASK: rdData = srqMask;
      SEL_QUERY:   rdData = stbQuery;
      SEL_POLL:    rdData = stbPoll;
      default:     rdData = '0;
    endcase
  end

  assign srqOut = rqsLatch;
endmodule

// File: rtl/stat_report_unit.sv
module stat_report_unit
  import stat_report_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int USER_W = BYTE_W - SUM_GAP
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        hostOp,
  input  logic [BYTE_W-1:0] hostWrData,
  output logic [BYTE_W-1:0] hostRdData,
  input  logic [BYTE_W-1:0] evtPulse,
  input  logic              queueNotEmpty,
  input  logic [USER_W-1:0] userSum,
  output logic              srqOut
);
  ctrlStrobe_t       strobe;
  logic [BYTE_W-1:0] evtReg;
  logic [BYTE_W-1:0] evtMask;
  logic [BYTE_W-1:0] srqMask;
  logic              mss;

  stat_report_ctrl u_ctrl (
    .hostOp (hostOp),
    .strobe (strobe)
  );

  stat_report_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .wrData        (hostWrData),
    .evtPulse      (evtPulse),
    .queueNotEmpty (queueNotEmpty),
    .userSum       (userSum),
    .rdData        (hostRdData),
    .srqOut        (srqOut),
    .evtReg        (evtReg),
    .evtMask       (evtMask),
    .srqMask       (srqMask),
    .mss           (mss)
  );
endmodule

// File: rtl/stat_report_chk.sv
module stat_report_chk
  import stat_report_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        hostOp,
  input logic [BYTE_W-1:0] hostRdData,
  input logic [BYTE_W-1:0] evtPulse,
  input logic              queueNotEmpty,
  input logic              srqOut,
  input logic [BYTE_W-1:0] evtReg,
  input logic [BYTE_W-1:0] evtMask,
  input logic [BYTE_W-1:0] srqMask,
  input logic              mss
);
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((evtReg & $past(evtPulse)) == $past(evtPulse))); // R1
  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    (hostOp != OP_RD_EVT) |=> ((evtReg & $past(evtReg)) == $past(evtReg))); // R1
  AST_EVT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (hostOp == OP_RD_EVT) |=> (evtReg == $past(evtPulse))); // R2
  AST_EVTMASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (hostOp != OP_WR_EVTMASK) |=> $stable(evtMask)); // R3
  AST_SRQMASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (hostOp != OP_WR_SRQMASK) |=> $stable(srqMask)); // R3
  AST_MAV_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (hostOp == OP_QUERY) |-> (hostRdData[MAV_POS] == queueNotEmpty)); // R5
  AST_QUERY_MSS: assert property (@(posedge clk) disable iff (!rstN)
    (hostOp == OP_QUERY) |-> (hostRdData[MSS_POS] == mss)); // R7
  AST_SRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (srqOut && hostOp != OP_POLL) |=> srqOut); // R8
  AST_POLL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (hostOp == OP_POLL && !mss) |=> !srqOut); // R9
  AST_POLL_BIT6: assert property (@(posedge clk) disable iff (!rstN)
    (hostOp == OP_POLL) |-> (hostRdData[MSS_POS] == srqOut)); // R9
endmodule

bind stat_report_unit stat_report_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .hostOp        (hostOp),
  .hostRdData    (hostRdData),
  .evtPulse      (evtPulse),
  .queueNotEmpty (queueNotEmpty),
  .srqOut        (srqOut),
  .evtReg        (evtReg),
  .evtMask       (evtMask),
  .srqMask       (srqMask),
  .mss           (mss)
);

// File: tb/stat_report_unit_bench.sv
`timescale 1ns/1ps
module stat_report_unit_bench;
  localparam logic [2:0] IDLE = 3'd0, RDE = 3'd1, RDEM = 3'd2, WREM = 3'd3,
                         RDSM = 3'd4, WRSM = 3'd5, QRY = 3'd6, POLL = 3'd7;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] hostOp = IDLE;
  logic [7:0] hostWrData = '0;
  logic [7:0] hostRdData;
  logic [7:0] evtPulse = '0;
  logic       queueNotEmpty = 1'b0;
  logic [4:0] userSum = '0;
  logic       srqOut;

  int testCount = 0;
  int failCount = 0;
  logic [7:0] rd;

  always #2 clk = ~clk;

  stat_report_unit u_stat_report_unit (
    .clk(clk), .rstN(rstN), .hostOp(hostOp), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .evtPulse(evtPulse), .queueNotEmpty(queueNotEmpty),
    .userSum(userSum), .srqOut(srqOut)
  );

  task automatic check(input string req, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive a code for one cycle, sample combinational read data mid-cycle
  task automatic hostDo(input logic [2:0] op, input logic [7:0] wd,
                        output logic [7:0] data);
    @(negedge clk);
    hostOp = op; hostWrData = wd;
    #1 data = hostRdData;
    @(posedge clk);
    #1 hostOp = IDLE;
  endtask

  task automatic pulse(input logic [7:0] p);
    @(negedge clk);
    evtPulse = p;
    @(posedge clk);
    #1 evtPulse = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] queryByte(input logic [7:0] base, input logic [7:0] m);
    logic [7:0] b = base & 8'hBF;
    b[6] = |(b & m);
    return b;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R10 srqOut in reset", srqOut, 0);
    @(negedge clk) rstN = 1'b1;
    idle(1);
    hostDo(RDE, 0, rd);  check("R10 event reg", rd, 0);
    hostDo(RDEM, 0, rd); check("R10 event mask", rd, 0);
    hostDo(RDSM, 0, rd); check("R10 service mask", rd, 0);

    // R1 latching of every bit, R2 clear on read
    for (int i = 0; i < 8; i++) begin
      pulse(8'(1 << i));
      idle(2);
      hostDo(RDE, 0, rd); check("R1 latched bit", rd, 1 << i);
      hostDo(RDE, 0, rd); check("R2 cleared after read", rd, 0);
    end
    pulse(8'h21);
    @(negedge clk);
    hostOp = RDE; evtPulse = 8'h08;
    #1 rd = hostRdData;
    @(posedge clk);
    #1 begin hostOp = IDLE; evtPulse = '0; end
    check("R2 read value with coincident pulse", rd, 8'h21);
    hostDo(RDE, 0, rd); check("R2 coincident pulse survives", rd, 8'h08);

    // R3 mask write and read back over the full value space
    for (int m = 0; m < 256; m++) begin
      hostDo(WREM, 8'(m), rd);
      hostDo(WRSM, 8'(255 - m), rd);
      hostDo(RDEM, 0, rd); check("R3 event mask readback", rd, m);
      hostDo(RDSM, 0, rd); check("R3 service mask readback", rd, 255 - m);
    end
    hostDo(QRY, 8'h5A, rd);
    hostDo(POLL, 8'h5A, rd);
    hostDo(RDEM, 0, rd); check("R3 mask untouched by other codes", rd, 255);
    hostDo(WRSM, 0, rd);
    hostDo(POLL, 0, rd);
    hostDo(RDE, 0, rd);

    // R4 event summary across all event masks
    foreach (pats[k]) begin
      hostDo(RDE, 0, rd);
      pulse(pats[k]);
      for (int m = 0; m < 256; m++) begin
        hostDo(WREM, 8'(m), rd);
        hostDo(QRY, 0, rd);
        check("R4 event summary byte", rd, ((pats[k] & m) != 0) ? 8'h20 : 8'h00);
      end
      hostDo(RDE, 0, rd); check("R7 query cleared nothing", rd, pats[k]);
    end
    hostDo(WREM, 0, rd);

    // R5 and R6 pins into the status byte
    for (int q = 0; q < 2; q++) begin
      for (int u = 0; u < 32; u++) begin
        @(negedge clk) begin queueNotEmpty = q[0]; userSum = 5'(u); end
        hostDo(QRY, 0, rd);
        check("R5 R6 status byte", rd, {u[4], 2'b00, q[0], u[3:0]});
      end
    end

    // R7 master summary across all service masks
    queueNotEmpty = 1'b1; userSum = 5'b10110;
    hostDo(WREM, 8'h10, rd);
    pulse(8'h10);
    for (int m = 0; m < 256; m++) begin
      hostDo(WRSM, 8'(m), rd);
      hostDo(QRY, 0, rd);
      check("R7 busy byte summary", rd, queryByte(8'hB6, 8'(m)));
    end
    queueNotEmpty = 1'b0; userSum = '0;
    hostDo(RDE, 0, rd);
    for (int m = 0; m < 256; m++) begin
      hostDo(WRSM, 8'(m), rd);
      hostDo(QRY, 0, rd);
      check("R7 idle byte summary", rd, 0);
    end

    // R8 and R9 request latch
    hostDo(WRSM, 8'h10, rd);
    hostDo(POLL, 0, rd);
    idle(1);
    check("R9 latch cleared before sequence", srqOut, 0);
    @(negedge clk) queueNotEmpty = 1'b1;
    idle(1);
    check("R8 set on summary rise", srqOut, 1);
    hostDo(QRY, 0, rd); check("R7 query shows summary", rd, 8'h50);
    check("R7 query keeps latch", srqOut, 1);
    hostDo(POLL, 0, rd); check("R9 poll returns latch", rd, 8'h50);
    check("R9 poll clears latch", srqOut, 0);
    hostDo(POLL, 0, rd); check("R9 poll shows cleared latch", rd, 8'h10);
    hostDo(QRY, 0, rd); check("R7 query shows live summary", rd, 8'h50);
    idle(3);
    check("R8 no set without new rise", srqOut, 0);
    @(negedge clk) queueNotEmpty = 1'b0;
    idle(1);
    @(negedge clk) queueNotEmpty = 1'b1;
    idle(1);
    check("R8 set on second rise", srqOut, 1);
    @(negedge clk) queueNotEmpty = 1'b0;
    idle(1);
    @(negedge clk) begin queueNotEmpty = 1'b1; hostOp = POLL; end
    #1 rd = hostRdData;
    @(posedge clk);
    #1 hostOp = IDLE;
    check("R9 poll bit6 on coincident rise", rd, 8'h50);
    check("R9 rise beats poll clear", srqOut, 1);
    hostDo(POLL, 0, rd);
    check("R9 poll clears without rise", srqOut, 0);

    // R8 chain: event pulse to event summary to request
    @(negedge clk) queueNotEmpty = 1'b0;
    hostDo(WRSM, 8'h20, rd);
    hostDo(WREM, 8'h04, rd);
    hostDo(POLL, 0, rd);
    pulse(8'h04);
    check("R8 chain one cycle after pulse", srqOut, 0);
    idle(1);
    check("R8 chain two cycles after pulse", srqOut, 1);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  logic [7:0] pats [4] = '{8'h01, 8'h80, 8'h24, 8'h00};
endmodule